// File: doc/BRIEF.md
# Peripheral Bus Width Bridge

This block sits between a 32-bit system bus and a slow byte-wide peripheral bus. Every system request is matched against a fixed address map of six windows: program store, working store, fast I/O, interrupt controller, and two peripheral register pages. The access size and direction are then checked against what the addressed window permits. Requests to the three memory-like windows and to the interrupt controller are handed unchanged to a local target port. Requests to either peripheral page are turned into one or two single-clock byte cycles on the peripheral bus.

A 16-bit access to a peripheral page becomes two consecutive byte cycles, even address first. The read bytes are assembled into the word before the system bus sees ready. Any access that the target window does not support is completed with an error response. An address that falls in no window is also completed with an error. In that case the block additionally raises either a one-cycle reset request or a one-cycle address-error exception, as selected by a configuration input.

Top module: `pbb_bridge`

## Requirements
- R1: Windows and target codes: 0x0000_0000 (128 KiB) code 0, 0x0080_0000 (8 KiB) code 1, 0x00C0_0000 (16 B) code 2, and 0xFFFF_FFC0 (64 B) code 3 go to the local port with `m_sel` and that code on `m_tgt`. 0xFFFF_8000 (128 B) and 0xFFFF_9800 (256 B) go to the peripheral bus, with `p_addr` equal to the low 16 address bits.
- R2: In the peripheral pages, byte (`s_size`=0) and word (`s_size`=1) reads and writes are accepted. A long access (`s_size`=2) is answered with `s_err` and issues no peripheral cycle.
- R3: An accepted peripheral word access issues exactly two byte cycles on consecutive clocks. The first is at the even address and carries the upper byte of the addressed half-word lane. The second is at the odd address and carries the lower byte.
- R4: On a peripheral word read, the first returned byte forms bits 15:8 and the second forms bits 7:0 of the half-word. `s_ack` rises only in the clock after the last byte cycle.
- R5: A peripheral word access at an odd address is answered with `s_err`, issues no peripheral cycle, and leaves the peripheral contents unchanged.
- R6: The code-0 window accepts reads of every size but only long writes. A byte or word write there is answered with `s_err` and issues no local cycle.
- R7: Windows with codes 1, 2 and 3 accept all three sizes for reads and writes. Read data from the local port is returned on `s_rdata` unmodified.
- R8: A word at an odd address, a long whose address is not a multiple of 4, and the reserved size code 3 are all answered with `s_err` and issue no cycle.
- R9: An address in no window is answered with `s_err`. With `cfg_exc_sel`=0 it also pulses `rst_req` together with `s_ack`; with `cfg_exc_sel`=1 it pulses `addr_exc` instead. Size or alignment errors inside a window raise neither.
- R10: `s_ack` is a one-cycle pulse. It comes 1 clock after acceptance for an error, 2 for a peripheral byte or a local access acknowledged at once, and 3 for a peripheral word.
- R11: At most one peripheral cycle is active per clock, `p_sel` lasts one clock per byte, and `s_req` is ignored while an access is in progress.
- R12: Lanes are big-endian: the byte at address offset k (k = `s_addr`[1:0]) occupies bits 31-8k down to 24-8k of `s_wdata`/`s_rdata`. A word with `s_addr`[1]=0 uses bits 31:16, and with `s_addr`[1]=1 uses bits 15:0. Unused read lanes return zero.
- R13: During and right after reset, `s_ack`, `p_sel`, `m_sel`, `rst_req` and `addr_exc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_exc_sel | input | 1 | Unmapped-address action: 0 reset request, 1 exception |
| s_req | input | 1 | System request, sampled when idle |
| s_addr | input | 32 | System byte address |
| s_size | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| s_write | input | 1 | 1 write, 0 read |
| s_wdata | input | 32 | System write data, big-endian lanes |
| s_ack | output | 1 | One-cycle completion |
| s_err | output | 1 | Error termination, valid with s_ack |
| s_rdata | output | 32 | Read data, valid with s_ack |
| rst_req | output | 1 | Reset request pulse for an unmapped address |
| addr_exc | output | 1 | Address-error exception pulse for an unmapped address |
| p_sel | output | 1 | Peripheral byte cycle strobe |
| p_wr | output | 1 | Peripheral cycle is a write |
| p_addr | output | 16 | Peripheral byte address |
| p_wdata | output | 8 | Peripheral write byte |
| p_rdata | input | 8 | Peripheral read byte, valid in the p_sel clock |
| m_sel | output | 1 | Local target request, held until m_ack |
| m_tgt | output | 2 | Local target code |
| m_addr | output | 32 | Local target address |
| m_size | output | 2 | Local target access size |
| m_write | output | 1 | Local target write |
| m_wdata | output | 32 | Local target write data |
| m_ack | input | 1 | Local target completion |
| m_rdata | input | 32 | Local target read data |

## Verification
A wrong sequencer state shows at the ports within one to three clocks. Typical symptoms are a missing or third `p_sel`, a second byte at the wrong address, `s_ack` arriving early or repeated, or a stray `m_sel`. A decode or permission fault shows in the very next clock as an `s_err` where none was due, or as a missing one. It can also appear as a wrong `m_tgt`, or as a reset or exception pulse on an error that lies inside a window. Lane-steering faults appear only in data. They are caught by writing through the bridge, reading back at different offsets, and comparing the byte log of the peripheral bus.

// File: rtl/pbb_pkg.sv
package pbb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;

   typedef enum logic [2:0] {
      RG_CODE   = 3'd0,
      RG_DATA   = 3'd1,
      RG_FASTIO = 3'd2,
      RG_INTC   = 3'd3,
      RG_PERIPH = 3'd4,
      RG_NONE   = 3'd7
   } region_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PB_HI = 3'd1,
      ST_PB_LO = 3'd2,
      ST_LOCAL = 3'd3,
      ST_RESP  = 3'd4
   } state_e;

   typedef struct packed {
      region_e region;
      logic    legal;
      logic    unmapped;
   } verdict_t;

   function automatic region_e region_of(int idx);
      case (idx)
         0:       return RG_CODE;
         1:       return RG_DATA;
         2:       return RG_FASTIO;
         3:       return RG_INTC;
         4, 5:    return RG_PERIPH;
         default: return RG_NONE;
      endcase
   endfunction

   function automatic logic size_ok(region_e rg, logic wr, size_e sz);
      case (rg)
         RG_CODE:                     return wr ? (sz == SZ_LONG) : (sz != SZ_RSVD);
         RG_DATA, RG_FASTIO, RG_INTC: return sz != SZ_RSVD;
         RG_PERIPH:                   return (sz == SZ_BYTE) || (sz == SZ_WORD);
         default:                     return 1'b0;
      endcase
   endfunction

   function automatic logic aligned(logic [1:0] lo, size_e sz);
      case (sz)
         SZ_BYTE: return 1'b1;
         SZ_WORD: return !lo[0];
         SZ_LONG: return lo == 2'b00;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/pbb_region_decode.sv
module pbb_region_decode
   import pbb_pkg::*;
#(
   parameter int            AW          = 32,
   parameter logic [AW-1:0] CODE_BASE   = 32'h0000_0000,
   parameter logic [AW-1:0] CODE_SPAN   = 32'h0002_0000,
   parameter logic [AW-1:0] DATA_BASE   = 32'h0080_0000,
   parameter logic [AW-1:0] DATA_SPAN   = 32'h0000_2000,
   parameter logic [AW-1:0] FIO_BASE    = 32'h00C0_0000,
   parameter logic [AW-1:0] FIO_SPAN    = 32'h0000_0010,
   parameter logic [AW-1:0] INTC_BASE   = 32'hFFFF_FFC0,
   parameter logic [AW-1:0] INTC_SPAN   = 32'h0000_0040,
   parameter logic [AW-1:0] PGA_BASE    = 32'hFFFF_8000,
   parameter logic [AW-1:0] PGA_SPAN    = 32'h0000_0080,
   parameter logic [AW-1:0] PGB_BASE    = 32'hFFFF_9800,
   parameter logic [AW-1:0] PGB_SPAN    = 32'h0000_0100
) (
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  size_e         sz,
   output verdict_t      verdict
);

   localparam int NREG = 6;
   localparam logic [NREG-1:0][AW-1:0] BASE_T =
      {PGB_BASE, PGA_BASE, INTC_BASE, FIO_BASE, DATA_BASE, CODE_BASE};
   localparam logic [NREG-1:0][AW-1:0] SPAN_T =
      {PGB_SPAN, PGA_SPAN, INTC_SPAN, FIO_SPAN, DATA_SPAN, CODE_SPAN};

   logic [NREG-1:0] hit;

   for (genvar g = 0; g < NREG; g++) begin : g_win
      localparam logic [AW-1:0] MASK = SPAN_T[g] - 1'b1;
      if (SPAN_T[g] == '0 || (SPAN_T[g] & MASK) != '0) begin : g_bad_span
         $error("window %0d span must be a nonzero power of two", g);
      end
      if ((BASE_T[g] & MASK) != '0) begin : g_bad_base
         $error("window %0d base must be aligned to its span", g);
      end
      assign hit[g] = (addr & ~MASK) == BASE_T[g];
   end

   region_e rg;

   always_comb begin
      rg = RG_NONE;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (hit[i]) rg = region_of(i);
      end
   end

   always_comb begin
      verdict.region   = rg;
      verdict.unmapped = (hit == '0);
      verdict.legal    = (hit != '0) && size_ok(rg, wr, sz) && aligned(addr[1:0], sz);
   end

endmodule

// File: rtl/pbb_lane_steer.sv
module pbb_lane_steer
   import pbb_pkg::*;
#(
   parameter int DW = 32,
   parameter int PW = 8,
   localparam int NLANE = DW / PW,
   localparam int LW    = $clog2(NLANE)
) (
   input  logic [LW-1:0] lane,
   input  size_e         sz,
   input  logic [DW-1:0] wdata,
   input  logic [PW-1:0] rd_hi,
   input  logic [PW-1:0] rd_lo,
   output logic [PW-1:0] wr_first,
   output logic [PW-1:0] wr_second,
   output logic [DW-1:0] rd_place
);

   if (NLANE != 4 || DW != NLANE * PW) begin : g_bad_width
      $error("system width must be exactly four peripheral bytes");
   end

   always_comb begin
      wr_first  = '0;
      wr_second = '0;
      rd_place  = '0;
      for (int l = 0; l < NLANE; l++) begin
         if (sz == SZ_BYTE && lane == LW'(l)) begin
            wr_first                    = wdata[DW-1-PW*l -: PW];
            rd_place[DW-1-PW*l -: PW]   = rd_hi;
         end
      end
      for (int h = 0; h < NLANE / 2; h++) begin
         if (sz == SZ_WORD && lane[LW-1:1] == (LW-1)'(h)) begin
            wr_first                          = wdata[DW-1-2*PW*h -: PW];
            wr_second                         = wdata[DW-1-2*PW*h-PW -: PW];
            rd_place[DW-1-2*PW*h -: PW]       = rd_hi;
            rd_place[DW-1-2*PW*h-PW -: PW]    = rd_lo;
         end
      end
   end

endmodule

// File: rtl/pbb_seq.sv
module pbb_seq
   import pbb_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int PW  = 8,
   parameter int PAW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_exc_sel,
   input  logic           s_req,
   input  logic [AW-1:0]  s_addr,
   input  size_e          s_size,
   input  logic           s_write,
   input  logic [DW-1:0]  s_wdata,
   input  verdict_t       verdict,
   input  logic [PW-1:0]  wr_first,
   input  logic [PW-1:0]  wr_second,
   input  logic [DW-1:0]  rd_place,
   input  logic [PW-1:0]  p_rdata,
   input  logic           m_ack,
   input  logic [DW-1:0]  m_rdata,
   output logic [AW-1:0]  addr_q,
   output size_e          size_q,
   output logic [DW-1:0]  wdata_q,
   output logic [PW-1:0]  hi_q,
   output logic [PW-1:0]  lo_q,
   output logic           s_ack,
   output logic           s_err,
   output logic [DW-1:0]  s_rdata,
   output logic           rst_req,
   output logic           addr_exc,
   output logic           p_sel,
   output logic           p_wr,
   output logic [PAW-1:0] p_addr,
   output logic [PW-1:0]  p_wdata,
   output logic           m_sel,
   output logic [1:0]     m_tgt,
   output logic           m_write
);

   if (PAW > AW) begin : g_bad_paw
      $error("peripheral address wider than system address");
   end

   state_e        state;
   region_e       rg_q;
   logic          wr_q;
   logic          err_q;
   logic          rst_q;
   logic          exc_q;
   logic [DW-1:0] loc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         rg_q    <= RG_NONE;
         wr_q    <= 1'b0;
         err_q   <= 1'b0;
         rst_q   <= 1'b0;
         exc_q   <= 1'b0;
         addr_q  <= '0;
         size_q  <= SZ_BYTE;
         wdata_q <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
         loc_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (s_req) begin
                  addr_q  <= s_addr;
                  size_q  <= s_size;
                  wr_q    <= s_write;
                  wdata_q <= s_wdata;
                  rg_q    <= verdict.region;
                  err_q   <= !verdict.legal;
                  rst_q   <= verdict.unmapped && !cfg_exc_sel;
                  exc_q   <= verdict.unmapped && cfg_exc_sel;
                  hi_q    <= '0;
                  lo_q    <= '0;
                  loc_q   <= '0;
                  if (!verdict.legal)                  state <= ST_RESP;
                  else if (verdict.region == RG_PERIPH) state <= ST_PB_HI;
                  else                                  state <= ST_LOCAL;
               end
            end
            ST_PB_HI: begin
               if (!wr_q) hi_q <= p_rdata;
               state <= (size_q == SZ_WORD) ? ST_PB_LO : ST_RESP;
            end
            ST_PB_LO: begin
               if (!wr_q) lo_q <= p_rdata;
               state <= ST_RESP;
            end
            ST_LOCAL: begin
               if (m_ack) begin
                  if (!wr_q) loc_q <= m_rdata;
                  state <= ST_RESP;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic in_resp;
   logic read_ok;

   always_comb begin
      in_resp  = (state == ST_RESP);
      read_ok  = in_resp && !err_q && !wr_q;
      s_ack    = in_resp;
      s_err    = in_resp && err_q;
      rst_req  = in_resp && rst_q;
      addr_exc = in_resp && exc_q;
      s_rdata  = '0;
      if (read_ok) s_rdata = (rg_q == RG_PERIPH) ? rd_place : loc_q;
      p_sel    = (state == ST_PB_HI) || (state == ST_PB_LO);
      p_wr     = p_sel && wr_q;
      p_addr   = '0;
      p_wdata  = '0;
      if (p_sel) begin
         p_addr = addr_q[PAW-1:0];
         if (state == ST_PB_LO) p_addr[0] = 1'b1;
         if (wr_q) p_wdata = (state == ST_PB_LO) ? wr_second : wr_first;
      end
      m_sel    = (state == ST_LOCAL);
      m_tgt    = m_sel ? rg_q[1:0] : 2'b00;
      m_write  = m_sel && wr_q;
   end

endmodule

// File: rtl/pbb_bridge.sv
module pbb_bridge
   import pbb_pkg::*;
#(
   parameter int           AW        = 32,
   parameter int           DW        = 32,
   parameter int           PW        = 8,
   parameter int           PAW       = 16,
   parameter logic [31:0]  CODE_BASE = 32'h0000_0000,
   parameter logic [31:0]  CODE_SPAN = 32'h0002_0000,
   parameter logic [31:0]  DATA_BASE = 32'h0080_0000,
   parameter logic [31:0]  DATA_SPAN = 32'h0000_2000,
   parameter logic [31:0]  FIO_BASE  = 32'h00C0_0000,
   parameter logic [31:0]  FIO_SPAN  = 32'h0000_0010,
   parameter logic [31:0]  INTC_BASE = 32'hFFFF_FFC0,
   parameter logic [31:0]  INTC_SPAN = 32'h0000_0040,
   parameter logic [31:0]  PGA_BASE  = 32'hFFFF_8000,
   parameter logic [31:0]  PGA_SPAN  = 32'h0000_0080,
   parameter logic [31:0]  PGB_BASE  = 32'hFFFF_9800,
   parameter logic [31:0]  PGB_SPAN  = 32'h0000_0100
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_exc_sel,
   input  logic           s_req,
   input  logic [31:0]    s_addr,
   input  logic [1:0]     s_size,
   input  logic           s_write,
   input  logic [31:0]    s_wdata,
   output logic           s_ack,
   output logic           s_err,
   output logic [31:0]    s_rdata,
   output logic           rst_req,
   output logic           addr_exc,
   output logic           p_sel,
   output logic           p_wr,
   output logic [15:0]    p_addr,
   output logic [7:0]     p_wdata,
   input  logic [7:0]     p_rdata,
   output logic           m_sel,
   output logic [1:0]     m_tgt,
   output logic [31:0]    m_addr,
   output logic [1:0]     m_size,
   output logic           m_write,
   output logic [31:0]    m_wdata,
   input  logic           m_ack,
   input  logic [31:0]    m_rdata
);

   localparam int LW = $clog2(DW / PW);

   if (AW != 32 || DW != 32 || PW != 8 || PAW != 16) begin : g_bad_cfg
      $error("port widths of this top are fixed at 32/32/8/16");
   end

   verdict_t      verdict;
   logic [AW-1:0] addr_q;
   size_e         size_q;
   logic [DW-1:0] wdata_q;
   logic [PW-1:0] hi_q;
   logic [PW-1:0] lo_q;
   logic [PW-1:0] wr_first;
   logic [PW-1:0] wr_second;
   logic [DW-1:0] rd_place;

   pbb_region_decode #(
      .AW(AW),
      .CODE_BASE(CODE_BASE), .CODE_SPAN(CODE_SPAN),
      .DATA_BASE(DATA_BASE), .DATA_SPAN(DATA_SPAN),
      .FIO_BASE(FIO_BASE),   .FIO_SPAN(FIO_SPAN),
      .INTC_BASE(INTC_BASE), .INTC_SPAN(INTC_SPAN),
      .PGA_BASE(PGA_BASE),   .PGA_SPAN(PGA_SPAN),
      .PGB_BASE(PGB_BASE),   .PGB_SPAN(PGB_SPAN)
   ) u_decode (
      .addr    (s_addr),
      .wr      (s_write),
      .sz      (size_e'(s_size)),
      .verdict (verdict)
   );

   pbb_lane_steer #(.DW(DW), .PW(PW)) u_lanes (
      .lane      (addr_q[LW-1:0]),
      .sz        (size_q),
      .wdata     (wdata_q),
      .rd_hi     (hi_q),
      .rd_lo     (lo_q),
      .wr_first  (wr_first),
      .wr_second (wr_second),
      .rd_place  (rd_place)
   );

   pbb_seq #(.AW(AW), .DW(DW), .PW(PW), .PAW(PAW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_exc_sel (cfg_exc_sel),
      .s_req       (s_req),
      .s_addr      (s_addr),
      .s_size      (size_e'(s_size)),
      .s_write     (s_write),
      .s_wdata     (s_wdata),
      .verdict     (verdict),
      .wr_first    (wr_first),
      .wr_second   (wr_second),
      .rd_place    (rd_place),
      .p_rdata     (p_rdata),
      .m_ack       (m_ack),
      .m_rdata     (m_rdata),
      .addr_q      (addr_q),
      .size_q      (size_q),
      .wdata_q     (wdata_q),
      .hi_q        (hi_q),
      .lo_q        (lo_q),
      .s_ack       (s_ack),
      .s_err       (s_err),
      .s_rdata     (s_rdata),
      .rst_req     (rst_req),
      .addr_exc    (addr_exc),
      .p_sel       (p_sel),
      .p_wr        (p_wr),
      .p_addr      (p_addr),
      .p_wdata     (p_wdata),
      .m_sel       (m_sel),
      .m_tgt       (m_tgt),
      .m_write     (m_write)
   );

   assign m_addr  = m_sel ? addr_q  : '0;
   assign m_size  = m_sel ? size_q  : 2'b00;
   assign m_wdata = m_sel ? wdata_q : '0;

endmodule

// File: rtl/pbb_checker.sv
module pbb_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        s_ack,
   input logic        s_err,
   input logic        rst_req,
   input logic        addr_exc,
   input logic        p_sel,
   input logic        p_wr,
   input logic [15:0] p_addr,
   input logic        m_sel
);

   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      s_ack |=> !s_ack);                                                        // R10
   AST_RST_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (s_ack && s_err && !addr_exc));                                // R9
   AST_EXC_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      addr_exc |-> (s_ack && s_err));                                           // R9
   AST_PAIR_ODD_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (p_sel && $past(p_sel)) |-> (p_addr[0] && p_addr[15:1] == $past(p_addr[15:1])
                                   && p_wr == $past(p_wr)));                    // R3
   AST_NO_THIRD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (p_sel && $past(p_sel)) |=> !p_sel);                                      // R11
   AST_ACK_AFTER_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(p_sel) |-> s_ack);                                                  // R4
   AST_NO_ERR_AFTER_PCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      s_err |-> !$past(p_sel));                                                 // R5
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !(p_sel && m_sel));                                                       // R11

endmodule

bind pbb_bridge pbb_checker u_pbb_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .s_ack    (s_ack),
   .s_err    (s_err),
   .rst_req  (rst_req),
   .addr_exc (addr_exc),
   .p_sel    (p_sel),
   .p_wr     (p_wr),
   .p_addr   (p_addr),
   .m_sel    (m_sel)
);

// File: tb/test_pbb_bridge.sv
module test_pbb_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_exc_sel = 1'b0;
   logic        s_req = 1'b0;
   logic [31:0] s_addr = '0;
   logic [1:0]  s_size = '0;
   logic        s_write = 1'b0;
   logic [31:0] s_wdata = '0;
   logic        s_ack, s_err, rst_req, addr_exc;
   logic [31:0] s_rdata;
   logic        p_sel, p_wr;
   logic [15:0] p_addr;
   logic [7:0]  p_wdata;
   logic [7:0]  p_rdata;
   logic        m_sel, m_write, m_ack;
   logic [1:0]  m_tgt, m_size;
   logic [31:0] m_addr, m_wdata, m_rdata;

   always #2 clk = ~clk;

   pbb_bridge i_pbb_bridge (
      .clk(clk), .rst_n(rst_n), .cfg_exc_sel(cfg_exc_sel),
      .s_req(s_req), .s_addr(s_addr), .s_size(s_size), .s_write(s_write),
      .s_wdata(s_wdata), .s_ack(s_ack), .s_err(s_err), .s_rdata(s_rdata),
      .rst_req(rst_req), .addr_exc(addr_exc),
      .p_sel(p_sel), .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
      .m_sel(m_sel), .m_tgt(m_tgt), .m_addr(m_addr), .m_size(m_size),
      .m_write(m_write), .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
   );

   // peripheral model: one byte per p_sel clock, reads combinational
   logic [7:0]  pmem [512];
   logic [15:0] plog_a [64];
   logic [7:0]  plog_d [64];
   int          pcnt = 0;
   int          mcnt = 0;
   logic [1:0]  last_tgt = '0;

   function automatic int pidx(logic [15:0] a);
      return {23'd0, a[12], a[7:0]};
   endfunction

   assign p_rdata = (p_sel && !p_wr) ? pmem[pidx(p_addr)] : 8'h00;
   assign m_ack   = m_sel;
   assign m_rdata = m_addr ^ 32'h5A5A_0000;

   always @(posedge clk) begin
      if (p_sel) begin
         if (p_wr) pmem[pidx(p_addr)] <= p_wdata;
         plog_a[pcnt % 64] <= p_addr;
         plog_d[pcnt % 64] <= p_wdata;
         pcnt <= pcnt + 1;
      end
      if (m_sel) begin
         last_tgt <= m_tgt;
         mcnt <= mcnt + 1;
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   logic [31:0] r_data;
   logic        r_err, r_rst, r_exc;
   int          r_lat;

   task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr, input logic [31:0] wd);
      @(negedge clk);
      s_req = 1'b1; s_addr = a; s_size = sz; s_write = wr; s_wdata = wd;
      r_lat = 0;
      do begin
         @(negedge clk);
         s_req = 1'b0;
         r_lat++;
      end while (!s_ack && r_lat < 20);
      r_data = s_rdata; r_err = s_err; r_rst = rst_req; r_exc = addr_exc;
   endtask

   task automatic t_reset();
      chk("R13", "s_ack", {31'd0, s_ack}, 0);
      chk("R13", "p_sel", {31'd0, p_sel}, 0);
      chk("R13", "m_sel", {31'd0, m_sel}, 0);
      chk("R13", "rst_req|addr_exc", {31'd0, rst_req | addr_exc}, 0);
   endtask

   task automatic t_pb_byte();
      int p0 = pcnt;
      access(32'hFFFF_8005, 2'd0, 1'b1, 32'h113C_2233);
      chk("R2", "byte write err", {31'd0, r_err}, 0);
      chk("R10", "byte latency", r_lat, 2);
      chk("R11", "byte cycles", pcnt - p0, 1);
      chk("R1", "byte p_addr", {16'd0, plog_a[p0 % 64]}, 32'h8005);
      chk("R12", "byte write lane", {24'd0, plog_d[p0 % 64]}, 32'h3C);
      access(32'hFFFF_8005, 2'd0, 1'b0, 32'h0);
      chk("R12", "byte read lane", r_data, 32'h003C_0000);
      access(32'hFFFF_9803, 2'd0, 1'b1, 32'hAAAA_AA77);
      access(32'hFFFF_9803, 2'd0, 1'b0, 32'h0);
      chk("R1", "high page readback", r_data, 32'h0000_0077);
   endtask

   task automatic t_pb_word();
      int p0 = pcnt;
      access(32'hFFFF_8010, 2'd1, 1'b1, 32'hBEEF_1234);
      chk("R10", "word latency", r_lat, 3);
      chk("R3", "word cycles", pcnt - p0, 2);
      chk("R3", "first addr", {16'd0, plog_a[p0 % 64]}, 32'h8010);
      chk("R3", "first data", {24'd0, plog_d[p0 % 64]}, 32'hBE);
      chk("R3", "second addr", {16'd0, plog_a[(p0 + 1) % 64]}, 32'h8011);
      chk("R3", "second data", {24'd0, plog_d[(p0 + 1) % 64]}, 32'hEF);
      access(32'hFFFF_8010, 2'd1, 1'b0, 32'h0);
      chk("R4", "word read upper half", r_data, 32'hBEEF_0000);
      chk("R4", "word read latency", r_lat, 3);
      access(32'hFFFF_8012, 2'd1, 1'b1, 32'h9999_C0DE);
      access(32'hFFFF_8012, 2'd1, 1'b0, 32'h0);
      chk("R12", "word read lower half", r_data, 32'h0000_C0DE);
      access(32'hFFFF_8011, 2'd0, 1'b0, 32'h0);
      chk("R12", "odd byte of word", r_data, 32'h00EF_0000);
   endtask

   task automatic t_pb_bad();
      int p0 = pcnt;
      access(32'hFFFF_8000, 2'd2, 1'b0, 32'h0);
      chk("R2", "long err", {31'd0, r_err}, 1);
      chk("R10", "error latency", r_lat, 1);
      chk("R9", "long no reset/exc", {30'd0, r_rst, r_exc}, 0);
      chk("R2", "long no cycle", pcnt - p0, 0);
      access(32'hFFFF_8011, 2'd1, 1'b1, 32'h5555_5555);
      chk("R5", "odd word err", {31'd0, r_err}, 1);
      chk("R5", "odd word no cycle", pcnt - p0, 0);
      access(32'hFFFF_8010, 2'd1, 1'b0, 32'h0);
      chk("R5", "contents unchanged", r_data, 32'hBEEF_0000);
   endtask

   task automatic t_unmapped();
      cfg_exc_sel = 1'b0;
      access(32'h1000_0000, 2'd0, 1'b0, 32'h0);
      chk("R9", "unmapped err", {31'd0, r_err}, 1);
      chk("R9", "cfg0 reset/exc", {30'd0, r_rst, r_exc}, 32'h2);
      cfg_exc_sel = 1'b1;
      access(32'h1000_0000, 2'd2, 1'b1, 32'h0);
      chk("R9", "cfg1 reset/exc", {30'd0, r_rst, r_exc}, 32'h1);
      access(32'hFFFF_8080, 2'd0, 1'b0, 32'h0);
      chk("R9", "page gap exc", {29'd0, r_err, r_rst, r_exc}, 32'h5);
      cfg_exc_sel = 1'b0;
   endtask

   task automatic t_local();
      int m0 = mcnt;
      access(32'h0000_0100, 2'd2, 1'b0, 32'h0);
      chk("R6", "code long read", r_data, 32'h5A5A_0100);
      chk("R1", "code target", {30'd0, last_tgt}, 0);
      chk("R10", "local latency", r_lat, 2);
      m0 = mcnt;
      access(32'h0000_0100, 2'd0, 1'b1, 32'h0);
      chk("R6", "code byte write err", {29'd0, r_err, r_rst, r_exc}, 32'h4);
      chk("R6", "code byte write no cycle", mcnt - m0, 0);
      access(32'h0000_0104, 2'd2, 1'b1, 32'h1234_5678);
      chk("R6", "code long write ok", {31'd0, r_err}, 0);
      access(32'h0080_0003, 2'd0, 1'b1, 32'h0000_00AA);
      chk("R7", "data byte write ok", {31'd0, r_err}, 0);
      chk("R1", "data target", {30'd0, last_tgt}, 1);
      access(32'h00C0_0002, 2'd1, 1'b0, 32'h0);
      chk("R7", "fastio word read", r_data, 32'h5A9A_0002);
      chk("R1", "fastio target", {30'd0, last_tgt}, 2);
      access(32'hFFFF_FFC4, 2'd2, 1'b0, 32'h0);
      chk("R7", "intc long read", r_data, 32'hA5A5_FFC4);
      chk("R1", "intc target", {30'd0, last_tgt}, 3);
      m0 = mcnt;
      access(32'h0080_0002, 2'd2, 1'b0, 32'h0);
      chk("R8", "misaligned long", {29'd0, r_err, r_rst, r_exc}, 32'h4);
      access(32'h0080_0001, 2'd1, 1'b0, 32'h0);
      chk("R8", "odd word", {31'd0, r_err}, 1);
      access(32'h0080_0000, 2'd3, 1'b0, 32'h0);
      chk("R8", "reserved size", {31'd0, r_err}, 1);
      chk("R8", "no local cycles", mcnt - m0, 0);
   endtask

   task automatic t_busy();
      int p0 = pcnt;
      @(negedge clk);
      s_req = 1'b1; s_addr = 32'hFFFF_8020; s_size = 2'd1; s_write = 1'b1; s_wdata = 32'hA1B2_0000;
      @(negedge clk);
      s_addr = 32'hFFFF_8040; s_size = 2'd0; s_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      s_req = 1'b0;
      @(negedge clk);
      chk("R10", "ack after word", {31'd0, s_ack}, 1);
      @(negedge clk);
      chk("R11", "busy cycles", pcnt - p0, 2);
      chk("R11", "busy second addr", {16'd0, plog_a[(p0 + 1) % 64]}, 32'h8021);
      access(32'hFFFF_8040, 2'd0, 1'b0, 32'h0);
      chk("R11", "held request ignored", r_data, 32'h0);
      access(32'hFFFF_8020, 2'd1, 1'b0, 32'h0);
      chk("R4", "busy word stored", r_data, 32'hA1B2_0000);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) pmem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pb_byte();
      t_pb_word();
      t_pb_bad();
      t_unmapped();
      t_local();
      t_busy();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule